// File: doc/BRIEF.md
# Real-time counter with alarm

This block keeps wall-clock time as a 32-bit count of periodic ticks. A programmable divider turns the block clock into ticks. Each tick advances the counter. The counter is compared against a 32-bit alarm value, and an overflow is noted when the counter rolls over. Software reaches every value through a small register bus of 16-bit words, so the wide values are accessed as upper and lower halves.

Changing the time base, the count or the alarm takes a guarded sequence. Software enters a configuration mode and writes the halves it wants into staging registers. On leaving the mode, those staged values are applied together and the divider restarts. A status bit then reads low for a short settling window, and every bus write during that window is dropped. A readable sync flag can be cleared by software and is raised again by the next tick. Three event flags, each with its own enable, are merged into one interrupt line.

The register map uses word addresses. 0 is the interrupt-enable word. 1 is the control and status word. 2 and 3 are the prescaler upper and lower halves. 4 and 5 are the counter upper and lower halves. 6 and 7 are the alarm upper and lower halves.

Top module: `rtcnt_top`

## Requirements
- R1: After reset the prescaler reads 0x8000 (upper half 0), the counter reads 0, the alarm reads 0xFFFF in both halves, the enable word reads 0, the control word reads 0x0020 and `irq` is low.
- R2: A write to address 2 through 7 has no visible effect unless the configuration bit (control word bit 4) is set, and even then the readable value changes only when a control-word write clears bit 4 while it was set (the commit).
- R3: After a commit that writes the prescaler or the counter, the divider restarts from the reload value. The counter then increments by exactly 1 every reload+1 clocks, the first increment landing reload+1 clocks after the commit edge.
- R4: Each tick sets control-word bit 0 (tick flag) and bit 3 (sync flag).
- R5: Control-word bit 1 (alarm flag) is set on the tick whose new counter value equals the alarm.
- R6: Control-word bit 2 (overflow flag) is set on the tick that takes the counter from 0xFFFFFFFF to 0.
- R7: Writing the control word clears each of bits 0 to 3 written as 0 and leaves each bit written as 1 unchanged. A write of 1 never sets a flag.
- R8: `irq` is high exactly when some flag in control-word bits 2:0 is set and its enable is set (enable word bits 2:0, same positions).
- R9: Control-word bit 5 (write idle) reads 0 for 3 clocks after the commit edge and 1 otherwise. Every bus write made while it is 0 is ignored.
- R10: Wide values read as two halves that combine as (upper << 16) | lower. The prescaler upper half holds the reload bits above bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the time base divided into ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Merged interrupt request |

## Verification
The assertions assume that a commit and a tick are separate events. Their counter-step and counter-hold properties exclude the commit cycle, because a committed counter value overrides the increment. The write-idle checks rely on the default settling window of three clocks being longer than one cycle. The stimulus keeps within these assumptions. Every configuration session begins only after write-idle has returned high, so no bus write is expected to land inside the window except the one deliberately dropped. Prescaler values are kept small so that tick-exact counter readings fall within a few dozen clocks of each commit.

// File: rtl/rtcnt_pkg.sv
package rtcnt_pkg;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned CNT_W   = 2 * HALF_W;
    localparam int unsigned NUM_SRC = 3;

    // word addresses of the register bus
    typedef enum logic [2:0] {
        A_IRQ_EN  = 3'd0,
        A_CTRL    = 3'd1,
        A_PRE_HI  = 3'd2,
        A_PRE_LO  = 3'd3,
        A_CNT_HI  = 3'd4,
        A_CNT_LO  = 3'd5,
        A_ALM_HI  = 3'd6,
        A_ALM_LO  = 3'd7
    } reg_addr_e;

    // bit positions in the control word
    localparam int unsigned FLG_TICK  = 0;
    localparam int unsigned FLG_ALM   = 1;
    localparam int unsigned FLG_OVF   = 2;
    localparam int unsigned BIT_SYNC  = 3;
    localparam int unsigned BIT_CFG   = 4;
    localparam int unsigned BIT_IDLE  = 5;

    // staged-value dirty markers
    localparam int unsigned DRT_PRE = 0;
    localparam int unsigned DRT_CNT = 1;
    localparam int unsigned DRT_ALM = 2;
endpackage

// File: rtl/rtcnt_divider.sv
module rtcnt_divider #(
    parameter int unsigned W       = 20,
    parameter logic [W-1:0] RST_VAL = W'(32'h8000)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == '0) && !load;
        if (load || tick) begin
            s_d.cnt = reload;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rtcnt_flags.sv
module rtcnt_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_keep,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] en,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } flg_t;

    flg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < int'(N); i++) begin
            // a software clear loses against a same-cycle hardware event
            if (clr_we && !clr_keep[i]) begin
                s_d.flags[i] = 1'b0;
            end
            if (ev[i]) begin
                s_d.flags[i] = 1'b1;
            end
        end
        if (en_we) begin
            s_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.flags;
    assign en    = s_q.en;
    assign irq   = |(s_q.flags & s_q.en);
endmodule

// File: rtl/rtcnt_top.sv
module rtcnt_top
    import rtcnt_pkg::*;
#(
    parameter int unsigned PRE_W    = 20,
    parameter logic [PRE_W-1:0] PRE_RST = PRE_W'(32'h8000),
    parameter int unsigned BUSY_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);
    localparam int unsigned PRE_HI_W = PRE_W - HALF_W;
    localparam int unsigned BUSY_W   = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  alm;
        logic [PRE_W-1:0]  stg_pre;
        logic [CNT_W-1:0]  stg_cnt;
        logic [CNT_W-1:0]  stg_alm;
        logic [2:0]        dirty;
        logic              cfg;
        logic              sync;
        logic [BUSY_W-1:0] busy;
    } state_t;

    state_t s_d, s_q;

    logic               wr_idle;
    logic               we_ok;
    logic               commit;
    logic               tick;
    logic               div_load;
    logic [CNT_W-1:0]   cnt_inc;
    logic [NUM_SRC-1:0] ev;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] irq_en;
    reg_addr_e          addr;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_idle = (s_q.busy == '0);
    assign we_ok   = bus_we && wr_idle;
    assign commit  = we_ok && (addr == A_CTRL) && s_q.cfg && !bus_wdata[BIT_CFG];
    assign cnt_inc = s_q.cnt + 1'b1;

    always_comb begin
        ev              = '0;
        ev[FLG_TICK]    = tick;
        ev[FLG_ALM]     = tick && (cnt_inc == s_q.alm);
        ev[FLG_OVF]     = tick && (&s_q.cnt);
    end

    always_comb begin
        s_d = s_q;
        if (s_q.busy != '0) begin
            s_d.busy = s_q.busy - 1'b1;
        end
        if (tick) begin
            s_d.cnt = cnt_inc;
        end
        if (we_ok) begin
            unique case (addr)
                A_CTRL: begin
                    s_d.cfg = bus_wdata[BIT_CFG];
                    if (!bus_wdata[BIT_SYNC]) begin
                        s_d.sync = 1'b0;
                    end
                    if (!s_q.cfg && bus_wdata[BIT_CFG]) begin
                        s_d.stg_pre = s_q.pre;
                        s_d.stg_cnt = s_q.cnt;
                        s_d.stg_alm = s_q.alm;
                        s_d.dirty   = '0;
                    end
                end
                A_PRE_HI: if (s_q.cfg) begin
                    s_d.stg_pre[PRE_W-1:HALF_W] = bus_wdata[PRE_HI_W-1:0];
                    s_d.dirty[DRT_PRE] = 1'b1;
                end
                A_PRE_LO: if (s_q.cfg) begin
                    s_d.stg_pre[HALF_W-1:0] = bus_wdata;
                    s_d.dirty[DRT_PRE] = 1'b1;
                end
                A_CNT_HI: if (s_q.cfg) begin
                    s_d.stg_cnt[CNT_W-1:HALF_W] = bus_wdata;
                    s_d.dirty[DRT_CNT] = 1'b1;
                end
                A_CNT_LO: if (s_q.cfg) begin
                    s_d.stg_cnt[HALF_W-1:0] = bus_wdata;
                    s_d.dirty[DRT_CNT] = 1'b1;
                end
                A_ALM_HI: if (s_q.cfg) begin
                    s_d.stg_alm[CNT_W-1:HALF_W] = bus_wdata;
                    s_d.dirty[DRT_ALM] = 1'b1;
                end
                A_ALM_LO: if (s_q.cfg) begin
                    s_d.stg_alm[HALF_W-1:0] = bus_wdata;
                    s_d.dirty[DRT_ALM] = 1'b1;
                end
                default: ;
            endcase
        end
        if (commit) begin
            if (s_q.dirty[DRT_PRE]) s_d.pre = s_q.stg_pre;
            if (s_q.dirty[DRT_CNT]) s_d.cnt = s_q.stg_cnt;
            if (s_q.dirty[DRT_ALM]) s_d.alm = s_q.stg_alm;
            s_d.dirty = '0;
            s_d.busy  = BUSY_W'(BUSY_CYC);
        end
        if (tick) begin
            s_d.sync = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pre <= PRE_RST;
            s_q.alm <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign div_load = commit && (s_q.dirty[DRT_PRE] || s_q.dirty[DRT_CNT]);

    rtcnt_divider #(
        .W       (PRE_W),
        .RST_VAL (PRE_RST)
    ) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (div_load),
        .reload (s_d.pre),
        .tick   (tick)
    );

    rtcnt_flags #(
        .N (NUM_SRC)
    ) flg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_we   (we_ok && (addr == A_CTRL)),
        .clr_keep (bus_wdata[NUM_SRC-1:0]),
        .en_we    (we_ok && (addr == A_IRQ_EN)),
        .en_wdata (bus_wdata[NUM_SRC-1:0]),
        .flags    (flags),
        .en       (irq_en),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            A_IRQ_EN: bus_rdata[NUM_SRC-1:0] = irq_en;
            A_CTRL: begin
                bus_rdata[NUM_SRC-1:0] = flags;
                bus_rdata[BIT_SYNC]    = s_q.sync;
                bus_rdata[BIT_CFG]     = s_q.cfg;
                bus_rdata[BIT_IDLE]    = wr_idle;
            end
            A_PRE_HI: bus_rdata = HALF_W'(s_q.pre[PRE_W-1:HALF_W]);
            A_PRE_LO: bus_rdata = s_q.pre[HALF_W-1:0];
            A_CNT_HI: bus_rdata = s_q.cnt[CNT_W-1:HALF_W];
            A_CNT_LO: bus_rdata = s_q.cnt[HALF_W-1:0];
            A_ALM_HI: bus_rdata = s_q.alm[CNT_W-1:HALF_W];
            A_ALM_LO: bus_rdata = s_q.alm[HALF_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtcnt_top_chk.sv
module rtcnt_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        commit,
    input logic [31:0] cnt,
    input logic        wr_idle,
    input logic [2:0]  flags,
    input logic [2:0]  irq_en,
    input logic        irq
);
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !commit) |=> (cnt == $past(cnt) + 32'd1));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !commit) |=> $stable(cnt));

    p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !commit && (&cnt)) |=> flags[2]);

    p_tick_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flags[0]);

    p_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wr_idle);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_idle) |=> !wr_idle);

    p_irq_no_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq);

    p_irq_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |-> !irq);
endmodule

bind rtcnt_top rtcnt_top_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .commit  (commit),
    .cnt     (s_q.cnt),
    .wr_idle (wr_idle),
    .flags   (flags),
    .irq_en  (irq_en),
    .irq     (irq)
);

// File: tb/rtcnt_top_tb_top.sv
module rtcnt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rtcnt_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // word: op(2) addr(3) data(16) mask(16) req(8); op 0 write, 1 check, 2 idle
    localparam int NV = 32;
    localparam logic [44:0] VEC [0:NV-1] = '{
        {2'd0, 3'd5, 16'h0009, 16'h0000, 8'd2},  // R2 write outside config mode
        {2'd1, 3'd5, 16'h0000, 16'hFFFF, 8'd2},  // R2 ignored
        {2'd0, 3'd1, 16'h0010, 16'h0000, 8'd2},  // enter config mode
        {2'd0, 3'd2, 16'h0000, 16'h0000, 8'd10},
        {2'd0, 3'd3, 16'h0003, 16'h0000, 8'd10},
        {2'd0, 3'd4, 16'h0000, 16'h0000, 8'd10},
        {2'd0, 3'd5, 16'h0005, 16'h0000, 8'd10},
        {2'd0, 3'd6, 16'h0000, 16'h0000, 8'd5},
        {2'd0, 3'd7, 16'h0007, 16'h0000, 8'd5},
        {2'd1, 3'd5, 16'h0000, 16'hFFFF, 8'd2},  // R2 staged only
        {2'd1, 3'd3, 16'h8000, 16'hFFFF, 8'd2},
        {2'd0, 3'd1, 16'h0000, 16'h0000, 8'd2},  // commit
        {2'd1, 3'd1, 16'h0000, 16'h003F, 8'd9},  // R9 busy right after commit
        {2'd1, 3'd5, 16'h0005, 16'hFFFF, 8'd3},  // R3 committed count
        {2'd1, 3'd3, 16'h0003, 16'hFFFF, 8'd10}, // R10 prescaler low half
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd1, 3'd1, 16'h0000, 16'h0020, 8'd9},  // R9 still busy at clock 2
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd1, 3'd1, 16'h0020, 16'h003F, 8'd9},  // R9 idle after 3 clocks
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd1, 3'd5, 16'h0006, 16'hFFFF, 8'd3},  // R3 first tick at reload+1
        {2'd1, 3'd1, 16'h0029, 16'h003F, 8'd4},  // R4 tick and sync flags
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd1, 3'd5, 16'h0006, 16'hFFFF, 8'd3},  // R3 no early tick
        {2'd1, 3'd1, 16'h0029, 16'h003F, 8'd5},  // R5 no alarm yet
        {2'd2, 3'd0, 16'h0000, 16'h0000, 8'd0},
        {2'd1, 3'd5, 16'h0007, 16'hFFFF, 8'd3},  // R3 second tick
        {2'd1, 3'd1, 16'h002B, 16'h003F, 8'd5},  // R5 alarm flag
        {2'd1, 3'd4, 16'h0000, 16'hFFFF, 8'd10}  // R10 upper half
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] exp,
                       input logic [15:0] mask, input int req);
        bus_addr = a;
        #1;
        n_cmp++;
        if ((bus_rdata & mask) !== exp) begin
            n_bad++;
            $display("FAIL R%0d addr %0d: got %h expected %h", req, a,
                     bus_rdata & mask, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input int req);
        #1;
        n_cmp++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL R%0d irq: got %b expected %b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk(3'd0, 16'h0000, 16'hFFFF, 1);
        chk(3'd1, 16'h0020, 16'hFFFF, 1);
        chk(3'd2, 16'h0000, 16'hFFFF, 1);
        chk(3'd3, 16'h8000, 16'hFFFF, 1);
        chk(3'd4, 16'h0000, 16'hFFFF, 1);
        chk(3'd5, 16'h0000, 16'hFFFF, 1);
        chk(3'd6, 16'hFFFF, 16'hFFFF, 1);
        chk(3'd7, 16'hFFFF, 16'hFFFF, 1);
        chk_irq(1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] e;
            e = VEC[i];
            case (e[44:43])
                2'd0:    wr(e[42:40], e[39:24]);
                2'd1:    chk(e[42:40], e[39:24], e[23:8], int'(e[7:0]));
                default: @(negedge clk);
            endcase
        end

        // R9 write during the settling window is dropped
        wr(3'd1, 16'h0010);
        wr(3'd1, 16'h0000);
        wr(3'd1, 16'h0010);
        chk(3'd1, 16'h0000, 16'h0030, 9);
        @(negedge clk);
        @(negedge clk);
        chk(3'd1, 16'h0020, 16'h0030, 9);

        // R6 overflow, R8 interrupt
        wr(3'd1, 16'h0010);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd1, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        wr(3'd0, 16'h0004);
        chk(3'd5, 16'h0000, 16'hFFFF, 6);
        chk(3'd4, 16'h0000, 16'hFFFF, 6);
        chk(3'd1, 16'h002D, 16'h003F, 6);
        chk_irq(1'b1, 8);
        chk(3'd0, 16'h0004, 16'hFFFF, 8);

        // R7 write zero clears, write one does not set
        wr(3'd1, 16'h0000);
        chk(3'd1, 16'h0020, 16'h003F, 7);
        chk_irq(1'b0, 8);
        wr(3'd1, 16'h0007);
        chk(3'd1, 16'h0020, 16'h003F, 7);
        chk_irq(1'b0, 7);

        // R10 committed alarm halves read back
        chk(3'd7, 16'h0007, 16'hFFFF, 10);
        chk(3'd6, 16'h0000, 16'hFFFF, 10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule